// File: doc/BRIEF.md
# Triangle-Carrier Delta Modulator

This block turns a stored sine reference into a single switching bit for a power stage. A digital triangle is made by an up/down counter. It climbs one step per enabled clock from zero to a programmable peak, then falls back to zero, and repeats. A second counter walks through a sine lookup table at a slow fixed rate. On every clock the current sine sample is compared with the current triangle value, and the result is registered as the output bit.

The peak input sets the modulation index: a lower peak gives a smaller triangle against the same sine amplitude. The peak is taken only when the triangle sits at zero, so each triangle period is complete and symmetric. The enable input freezes the carrier, the table address and the rate divider. The compare keeps running while enable is low, so the output stays steady.

Top module: `triangle_delta_mod`

## Requirements
- R1: While reset is high, and on the first clock after it is released, modOut is 0; the carrier starts at 0 and rising, and the table address and rate divider start at 0.
- R2: On each clock with enable high, the carrier moves by exactly one step. It rises from 0 to the active peak and then falls back to 0. The direction turns on reaching either end value, so neither 0 nor the peak appears on two clocks in a row, and one period lasts 2·peak enabled clocks.
- R3: peakIn is sampled into the active peak only on an enabled clock where the carrier equals 0. A change at any other time has no effect on the carrier until its next zero.
- R4: A peakIn value of 0 is treated as 1, so the carrier alternates between 0 and 1.
- R5: Table entry k (0 ≤ k < DEPTH) holds floor(h + h·sin(2πk/DEPTH) + 0.5), where h = (2^CNT_W − 1)/2. For the default 4-bit width and 64 entries this spans 0..15.
- R6: The table address advances by one after every STEP_CYCLES enabled clocks and wraps from DEPTH−1 to 0.
- R7: Each clock, modOut is set to 1 when the table sample at the current address is greater than or equal to the current carrier value, and to 0 otherwise. Both values are those held before that edge, so the output lags the state by one clock.
- R8: With enable low, the carrier, its direction, the active peak, the table address and the rate divider all hold. modOut keeps the compare result of the frozen state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Advances carrier and reference when high |
| peakIn | input | CNT_W | Requested carrier peak (modulation index) |
| modOut | output | 1 | Registered delta-modulated switching bit |

## Verification
The bench builds the block with a 4-bit carrier, the 64-entry table and STEP_CYCLES set to 3. With these values one lap of the sine reference takes only 192 enabled clocks, so the run covers several full laps and address wraps. It also sweeps every peak value from 0 to 15, changes the peak partway through a ramp, and gates enable in several patterns. The bench models the carrier, the divider and the table arithmetically and compares modOut on every clock.

// File: rtl/dmod_pkg.sv
package dmod_pkg;

  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic loadPeak;
    logic advPhase;
  } dmodStrobe_t;

  // Offset sine level for table slot idx, rounded to nearest integer
  function automatic int sineLevel(int idx, int depth, int width);
    real half;
    real v;
    half = ((2.0 ** width) - 1.0) / 2.0;
    v = half + half * $sin(2.0 * 3.14159265358979 * real'(idx) / real'(depth));
    return int'($floor(v + 0.5));
  endfunction

endpackage

// File: rtl/dmod_ctrl.sv
module dmod_ctrl
  import dmod_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int STEP_CYCLES = 7812
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CNT_W-1:0] peakIn,
  input  logic [CNT_W-1:0] carrier,
  input  logic [CNT_W-1:0] peakActive,
  output dmodStrobe_t      strobe,
  output logic [CNT_W-1:0] loadValue
);

  localparam int TMR_W = $clog2(STEP_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(STEP_CYCLES - 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             dirUp;
  logic [TMR_W-1:0] timer;
  logic [CNT_W-1:0] effPeak;
  logic             atZero;

  always_comb begin
    atZero    = (carrier == '0);
    loadValue = (peakIn == '0) ? ONE : peakIn;
    effPeak   = atZero ? loadValue : peakActive;
    strobe          = '0;
    strobe.stepUp   = enable && dirUp;
    strobe.stepDown = enable && !dirUp;
    strobe.loadPeak = enable && atZero;
    strobe.advPhase = enable && (timer == TMR_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dirUp <= 1'b1;
      timer <= '0;
    end else if (enable) begin
      timer <= (timer == TMR_LAST) ? '0 : timer + TMR_W'(1);
      if (dirUp && (carrier + ONE == effPeak))
        dirUp <= 1'b0;
      else if (!dirUp && (carrier == ONE))
        dirUp <= 1'b1;
    end
  end

  // R2: at the bottom of the triangle the counter must be heading up
  assert_dir_at_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (carrier == '0) |-> dirUp);

  // R2: at the top of the triangle the counter must be heading down
  assert_dir_at_peak_R2: assert property (@(posedge clk) disable iff (rst)
    (carrier == peakActive && carrier != '0) |-> !dirUp);

  // R6: divider never leaves its range
  assert_timer_range_R6: assert property (@(posedge clk) disable iff (rst)
    timer <= TMR_LAST);

endmodule

// File: rtl/dmod_datapath.sv
module dmod_datapath
  import dmod_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  dmodStrobe_t      strobe,
  input  logic [CNT_W-1:0] loadValue,
  output logic [CNT_W-1:0] carrier,
  output logic [CNT_W-1:0] peakActive,
  output logic             modOut
);

  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0]  sineTab [DEPTH];
  logic [ADDR_W-1:0] phase;
  logic [CNT_W-1:0]  sineNow;

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign sineTab[g] = CNT_W'(sineLevel(g, DEPTH, CNT_W));
  end

  assign sineNow = sineTab[phase];

  always_ff @(posedge clk) begin
    if (rst) begin
      carrier    <= '0;
      peakActive <= '1;
      phase      <= '0;
      modOut     <= 1'b0;
    end else begin
      modOut <= (sineNow >= carrier);
      if (strobe.loadPeak) peakActive <= loadValue;
      if (strobe.stepUp)        carrier <= carrier + ONE;
      else if (strobe.stepDown) carrier <= carrier - ONE;
      if (strobe.advPhase)
        phase <= (phase == ADDR_LAST) ? '0 : phase + ADDR_W'(1);
    end
  end

  // R2: carrier never exceeds the active peak
  assert_carrier_range_R2: assert property (@(posedge clk) disable iff (rst)
    carrier <= peakActive);

  // R3: peak stays put while the triangle is away from zero
  assert_peak_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (carrier != '0) |=> $stable(peakActive));

  // R8: with no strobes, all state holds
  assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    (strobe == '0) |=> ($stable(carrier) && $stable(phase) && $stable(peakActive)));

  // R2: a step strobe moves the carrier, never leaving it unchanged
  assert_moves_R2: assert property (@(posedge clk) disable iff (rst)
    (strobe.stepUp || strobe.stepDown) |=> !$stable(carrier));

endmodule

// File: rtl/triangle_delta_mod.sv
module triangle_delta_mod
  import dmod_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int DEPTH       = 64,
  parameter int STEP_CYCLES = 7812
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CNT_W-1:0] peakIn,
  output logic             modOut
);

  dmodStrobe_t      strobe;
  logic [CNT_W-1:0] loadValue;
  logic [CNT_W-1:0] carrier;
  logic [CNT_W-1:0] peakActive;

  dmod_ctrl #(.CNT_W(CNT_W), .STEP_CYCLES(STEP_CYCLES)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .peakIn     (peakIn),
    .carrier    (carrier),
    .peakActive (peakActive),
    .strobe     (strobe),
    .loadValue  (loadValue)
  );

  dmod_datapath #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .loadValue  (loadValue),
    .carrier    (carrier),
    .peakActive (peakActive),
    .modOut     (modOut)
  );

  // R1: output low on the clock after reset
  assert_reset_out_R1: assert property (@(posedge clk)
    rst |=> !modOut);

endmodule

// File: tb/triangle_delta_mod_tb.sv
module triangle_delta_mod_tb;

  localparam int CNT_W = 4;
  localparam int DEPTH = 64;
  localparam int STEP  = 3;

  logic             clk = 1'b0;
  logic             rst;
  logic             enable;
  logic [CNT_W-1:0] peakIn;
  logic             modOut;

  int nChecks = 0;
  int nFails  = 0;
  bit checking = 1'b0;
  bit done = 1'b0;
  string curTag = "R1";

  int sTab [DEPTH];
  int mCar, mDir, mPeak, mPhase, mTimer, mOut;

  always #10 clk = ~clk;

  triangle_delta_mod #(.CNT_W(CNT_W), .DEPTH(DEPTH), .STEP_CYCLES(STEP)) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .peakIn(peakIn), .modOut(modOut)
  );

  // Reference model built from the requirements
  always @(posedge clk) begin
    int newOut;
    if (rst) begin
      mCar = 0; mDir = 1; mPeak = (1 << CNT_W) - 1;
      mPhase = 0; mTimer = 0; mOut = 0;
    end else begin
      newOut = (sTab[mPhase] >= mCar) ? 1 : 0;
      if (enable) begin
        if (mCar == 0) mPeak = (peakIn == 0) ? 1 : int'(peakIn);
        if (mDir != 0) begin
          mCar = mCar + 1;
          if (mCar == mPeak) mDir = 0;
        end else begin
          mCar = mCar - 1;
          if (mCar == 0) mDir = 1;
        end
        if (mTimer == STEP - 1) begin
          mTimer = 0;
          mPhase = (mPhase + 1) % DEPTH;
        end else mTimer = mTimer + 1;
      end
      mOut = newOut;
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      nChecks++;
      if (int'(modOut) != mOut) begin
        nFails++;
        $display("FAIL %s: modOut=%0d expected %0d at %0t", curTag, modOut, mOut, $time);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      real h;
      h = ((2.0 ** CNT_W) - 1.0) / 2.0;
      sTab[k] = int'($floor(h + h * $sin(2.0 * 3.14159265358979 * real'(k) / real'(DEPTH)) + 0.5));
    end
  end

  initial begin
    rst = 1'b1; enable = 1'b0; peakIn = 4'd15;
    run(2);
    checking = 1'b1;
    curTag = "R1";
    run(3);
    rst = 1'b0;
    run(2);
    // R7: full-scale compare over two reference laps
    curTag = "R7"; enable = 1'b1;
    run(2 * DEPTH * STEP);
    // R5: table contents seen through the compare at full peak
    curTag = "R5";
    run(DEPTH * STEP);
    // R2 / R4: sweep every peak value
    for (int p = 0; p < 16; p++) begin
      curTag = (p == 0) ? "R4" : "R2";
      peakIn = CNT_W'(p);
      run(120);
    end
    // R3: peak changed mid-ramp
    curTag = "R3";
    for (int i = 0; i < 60; i++) begin
      peakIn = CNT_W'((i * 5 + 3) % 16);
      run(7);
    end
    // R8: gated enable, including a long pause with a peak change
    curTag = "R8";
    peakIn = 4'd11;
    for (int i = 0; i < 300; i++) begin
      enable = (i % 3 != 0);
      run(1);
    end
    enable = 1'b0; peakIn = 4'd2;
    run(50);
    enable = 1'b1;
    run(40);
    // R6: small peak exposes address stepping and wrap
    curTag = "R6"; peakIn = 4'd1;
    run(2 * DEPTH * STEP + 10);
    checking = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule